// File: doc/BRIEF.md
# Two-Slot Limited Out-of-Order Dispatch Unit

This block takes decoded, non-branch instructions from the head of an in-order instruction queue and places them into one of three execution pipelines: integer, floating point or special. Each pipeline has a single reservation station. Branches have already been resolved upstream, so every queue entry seen here targets one of these three classes. Each cycle the unit looks at only the two oldest queue entries. It reports back to the queue which of the two slots it consumed. When the older entry is taken and the younger is not, the younger stays at the head. When only the younger is taken, it is removed from behind the older one.

Reordering is possible only across classes. A younger instruction may pass an older, stalled instruction when their classes differ and its own station is free. Two instructions of the same class always leave in program order. Each class keeps its own register file scoreboard, so no dependence is tracked across classes. An occupied station issues to its pipeline once its two source registers and its destination register are all marked ready in that class's scoreboard. Issue marks the destination pending, and a writeback from the pipeline marks it ready again. A flush empties all stations and dispatches nothing in that cycle.

Top module: `lim_dispatch`

## Requirements
- R1: After reset no issue is signalled, no slot is taken and every scoreboard bit of every class reads 1 (ready).
- R2: Slot 0 is taken (take[0]=1) in a cycle when it is valid, its class code is 0 (integer), 1 (floating point) or 2 (special), the station of that class is empty at the start of the cycle and flush is low. The instruction is in the station from the next cycle.
- R3: A station holds at most one instruction. While it is occupied, no slot of its class is taken. It can be loaded again in the cycle after its instruction issues.
- R4: Slot 1 is never taken when slot 0 is valid and has the same class code, even if slot 0 is not taken.
- R5: Slot 1 with a valid class different from slot 0's class is taken (take=2'b10) when its station is empty, even if slot 0 is blocked.
- R6: When both slots are valid, have different valid classes and both stations are empty, both are taken in one cycle (take=2'b11).
- R7: iss_valid[c] is 1 exactly when station c is occupied, flush is low, and the scoreboard bits of class c for the station's source A, source B and destination are all 1. The issue tag outputs of class c (bits c*REG_W upward) then carry those register numbers.
- R8: An issue clears the destination's scoreboard bit from the next cycle. A writeback sets the written register's bit from the next cycle. If an issue and a writeback name the same register in the same cycle, the bit ends up cleared.
- R9: Scoreboards are per class. An issue or writeback in one class leaves the bits of the other classes unchanged. Bit r of class c is sb_ready[c*NUM_REGS+r].
- R10: While flush is high, take is 2'b00 and iss_valid is all zero. Every station is empty in the next cycle, and the scoreboards are not changed by the flush.
- R11: Class code 3 is reserved and such an entry is never taken. A valid younger entry of a valid class may still be taken past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Empty all stations and dispatch nothing this cycle |
| q_valid | input | 2 | Valid bits of the two oldest queue entries (bit 0 = oldest) |
| q_cls | input | 4 | Class codes, slot k at bits [2k+1:2k] |
| q_dst | input | 2*REG_W | Destination register numbers, slot k at k*REG_W |
| q_src_a | input | 2*REG_W | First source register numbers, slot k at k*REG_W |
| q_src_b | input | 2*REG_W | Second source register numbers, slot k at k*REG_W |
| take | output | 2 | Slots consumed this cycle (bit k = slot k) |
| wb_valid | input | 3 | Writeback strobe per class |
| wb_reg | input | 3*REG_W | Written register per class, class c at c*REG_W |
| iss_valid | output | 3 | Issue strobe per class |
| iss_dst | output | 3*REG_W | Issued destination register per class |
| iss_src_a | output | 3*REG_W | Issued first source per class |
| iss_src_b | output | 3*REG_W | Issued second source per class |
| sb_ready | output | 3*NUM_REGS | Scoreboard ready bits, class c at c*NUM_REGS |

## Verification
Directed patterns come first. A mixed-class pair with both stations empty separates dual dispatch from single dispatch. A same-class pair shows that in-order holding is kept even while slot 0 is taken. A blocked integer head with a floating-point follower shows that the younger entry passes the older one. A reserved-code head and a flush with occupied stations cover the edges of slot selection. A writeback in one class next to a pending bit in another shows that the scoreboards are separate. After that, seeded random windows with random writebacks and rare flushes run against a bench model of stations and scoreboards. This model covers same-register issue/writeback collisions and reload in the cycle after issue.

// File: rtl/lim_dispatch_pkg.sv
package lim_dispatch_pkg;
  localparam int NUM_CLS = 3;
  localparam int SLOTS   = 2;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_FP  = 2'd1,
    CLS_SPC = 2'd2,
    CLS_RSV = 2'd3
  } cls_e;
endpackage

// File: rtl/ldp_window_pick.sv
module ldp_window_pick
  import lim_dispatch_pkg::*;
(
  input  logic [1:0]         valid,
  input  logic [1:0]         cls0,
  input  logic [1:0]         cls1,
  input  logic [NUM_CLS-1:0] st_free,
  input  logic               flush,
  output logic [1:0]         take
);
  logic [3:0] free_ext;
  logic       ok0;
  logic       ok1;
  logic       same_cls;

  always_comb begin
    free_ext = {1'b0, st_free};
    same_cls = valid[0] && (cls0 == cls1);
    ok0      = valid[0] && (cls0 != CLS_RSV) && free_ext[cls0];
    ok1      = valid[1] && (cls1 != CLS_RSV) && free_ext[cls1] && !same_cls;
    take     = flush ? 2'b00 : {ok1, ok0};
  end
endmodule

// File: rtl/ldp_station.sv
module ldp_station #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             load,
  input  logic [REG_W-1:0] ld_dst,
  input  logic [REG_W-1:0] ld_a,
  input  logic [REG_W-1:0] ld_b,
  input  logic             issue,
  output logic             occ,
  output logic [REG_W-1:0] dst,
  output logic [REG_W-1:0] src_a,
  output logic [REG_W-1:0] src_b
);
  logic occ_nx;

  always_comb begin
    occ_nx = occ;
    if (flush) begin
      occ_nx = 1'b0;
    end else begin
      if (issue) occ_nx = 1'b0;
      if (load)  occ_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= 1'b0;
    else        occ <= occ_nx;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      dst   <= ld_dst;
      src_a <= ld_a;
      src_b <= ld_b;
    end
  end

  // R3: a station is only written while empty
  assert_load_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !occ);
  // R7: issue comes only from an occupied station and frees it
  assert_issue_needs_occ_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> occ);
  assert_issue_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !occ);
  // R10: flush empties the station
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !occ);
endmodule

// File: rtl/ldp_scoreboard.sv
module ldp_scoreboard #(
  parameter int NUM_REGS = 32,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [REG_W-1:0]    set_idx,
  input  logic                clr_en,
  input  logic [REG_W-1:0]    clr_idx,
  output logic [NUM_REGS-1:0] rdy
);
  logic [NUM_REGS-1:0] rdy_nx;

  always_comb begin
    rdy_nx = rdy;
    if (set_en) rdy_nx[set_idx] = 1'b1;
    if (clr_en) rdy_nx[clr_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy <= '1;
    else        rdy <= rdy_nx;
  end

  // R8: issue marks destination pending, writeback marks it ready
  assert_clear_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !rdy[$past(clr_idx)]);
  assert_set_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !(clr_en && clr_idx == set_idx)) |=> rdy[$past(set_idx)]);
endmodule

// File: rtl/lim_dispatch.sv
module lim_dispatch
  import lim_dispatch_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic [SLOTS-1:0]            q_valid,
  input  logic [2*SLOTS-1:0]          q_cls,
  input  logic [SLOTS*REG_W-1:0]      q_dst,
  input  logic [SLOTS*REG_W-1:0]      q_src_a,
  input  logic [SLOTS*REG_W-1:0]      q_src_b,
  output logic [SLOTS-1:0]            take,
  input  logic [NUM_CLS-1:0]          wb_valid,
  input  logic [NUM_CLS*REG_W-1:0]    wb_reg,
  output logic [NUM_CLS-1:0]          iss_valid,
  output logic [NUM_CLS*REG_W-1:0]    iss_dst,
  output logic [NUM_CLS*REG_W-1:0]    iss_src_a,
  output logic [NUM_CLS*REG_W-1:0]    iss_src_b,
  output logic [NUM_CLS*NUM_REGS-1:0] sb_ready
);
  logic       rst_meta_n;
  logic       rst_sync_n;
  logic [1:0] cls0;
  logic [1:0] cls1;
  logic [NUM_CLS-1:0] st_occ;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign cls0 = q_cls[1:0];
  assign cls1 = q_cls[3:2];

  ldp_window_pick u_pick (
    .valid   (q_valid),
    .cls0    (cls0),
    .cls1    (cls1),
    .st_free (~st_occ),
    .flush   (flush),
    .take    (take)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic                load;
    logic                from_slot1;
    logic [REG_W-1:0]    ld_dst;
    logic [REG_W-1:0]    ld_a;
    logic [REG_W-1:0]    ld_b;
    logic [REG_W-1:0]    s_dst;
    logic [REG_W-1:0]    s_a;
    logic [REG_W-1:0]    s_b;
    logic [NUM_REGS-1:0] rdy;
    logic                src_ok;
    logic                issue;

    always_comb begin
      from_slot1 = !(take[0] && cls0 == 2'(c));
      load       = (take[0] && cls0 == 2'(c)) || (take[1] && cls1 == 2'(c));
      ld_dst     = from_slot1 ? q_dst[REG_W +: REG_W]   : q_dst[0 +: REG_W];
      ld_a       = from_slot1 ? q_src_a[REG_W +: REG_W] : q_src_a[0 +: REG_W];
      ld_b       = from_slot1 ? q_src_b[REG_W +: REG_W] : q_src_b[0 +: REG_W];
      src_ok     = rdy[s_a] && rdy[s_b] && rdy[s_dst];
      issue      = st_occ[c] && src_ok && !flush;
    end

    ldp_station #(.REG_W(REG_W)) u_st (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .flush  (flush),
      .load   (load),
      .ld_dst (ld_dst),
      .ld_a   (ld_a),
      .ld_b   (ld_b),
      .issue  (issue),
      .occ    (st_occ[c]),
      .dst    (s_dst),
      .src_a  (s_a),
      .src_b  (s_b)
    );

    ldp_scoreboard #(.NUM_REGS(NUM_REGS)) u_sb (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .set_en  (wb_valid[c]),
      .set_idx (wb_reg[c*REG_W +: REG_W]),
      .clr_en  (issue),
      .clr_idx (s_dst),
      .rdy     (rdy)
    );

    assign iss_valid[c]                = issue;
    assign iss_dst[c*REG_W +: REG_W]   = s_dst;
    assign iss_src_a[c*REG_W +: REG_W] = s_a;
    assign iss_src_b[c*REG_W +: REG_W] = s_b;
    assign sb_ready[c*NUM_REGS +: NUM_REGS] = rdy;
  end

  // R4: the younger slot never leaves ahead of a valid same-class older slot
  assert_same_class_order_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take[1] && q_valid[0]) |-> (cls0 != cls1));
  // R11: a reserved class code is never consumed
  assert_reserved_stays_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (q_valid[0] && cls0 == CLS_RSV) |-> !take[0]);
endmodule

// File: tb/tb_lim_dispatch.sv
module tb_lim_dispatch;
  localparam int NR = 8;
  localparam int RW = $clog2(NR);
  localparam int NC = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic flush;
  logic [1:0] q_valid;
  logic [3:0] q_cls;
  logic [2*RW-1:0] q_dst, q_src_a, q_src_b;
  logic [1:0] take;
  logic [NC-1:0] wb_valid;
  logic [NC*RW-1:0] wb_reg;
  logic [NC-1:0] iss_valid;
  logic [NC*RW-1:0] iss_dst, iss_src_a, iss_src_b;
  logic [NC*NR-1:0] sb_ready;

  int checks = 0;
  int fails  = 0;

  bit           m_occ [NC];
  int           m_d [NC];
  int           m_a [NC];
  int           m_b [NC];
  bit           m_sb [NC][NR];

  always #2 clk = ~clk;

  lim_dispatch #(.NUM_REGS(NR)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .q_valid(q_valid), .q_cls(q_cls), .q_dst(q_dst),
    .q_src_a(q_src_a), .q_src_b(q_src_b), .take(take),
    .wb_valid(wb_valid), .wb_reg(wb_reg),
    .iss_valid(iss_valid), .iss_dst(iss_dst),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .sb_ready(sb_ready)
  );

  function automatic bit exp_ready(int c);
    return m_sb[c][m_a[c]] && m_sb[c][m_b[c]] && m_sb[c][m_d[c]];
  endfunction

  function automatic logic [1:0] exp_take();
    logic [1:0] c0, c1;
    bit t0, t1;
    c0 = q_cls[1:0];
    c1 = q_cls[3:2];
    t0 = !flush && q_valid[0] && c0 != 2'd3 && !m_occ[c0];
    t1 = !flush && q_valid[1] && c1 != 2'd3 && !m_occ[c1] &&
         !(q_valid[0] && c0 == c1);
    return {t1, t0};
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic set_slot(int k, int cls, int d, int a, int b, bit v);
    q_valid[k]         = v;
    q_cls[2*k +: 2]    = 2'(cls);
    q_dst[k*RW +: RW]   = RW'(d);
    q_src_a[k*RW +: RW] = RW'(a);
    q_src_b[k*RW +: RW] = RW'(b);
  endtask

  task automatic idle_inputs();
    flush = 1'b0; q_valid = '0; q_cls = '0; q_dst = '0;
    q_src_a = '0; q_src_b = '0; wb_valid = '0; wb_reg = '0;
  endtask

  // inputs already driven after a negedge; compare, advance model, wait next negedge
  task automatic cycle(string tag);
    logic [1:0] et;
    bit ei [NC];
    #1;
    et = exp_take();
    chk(tag, "take", int'(take), int'(et));
    for (int c = 0; c < NC; c++) begin
      ei[c] = !flush && m_occ[c] && exp_ready(c);
      chk("R7", $sformatf("iss_valid[%0d]", c), int'(iss_valid[c]), int'(ei[c]));
      if (ei[c]) begin
        chk("R7", $sformatf("iss_dst[%0d]", c), int'(iss_dst[c*RW +: RW]), m_d[c]);
        chk("R7", $sformatf("iss_src_a[%0d]", c), int'(iss_src_a[c*RW +: RW]), m_a[c]);
        chk("R7", $sformatf("iss_src_b[%0d]", c), int'(iss_src_b[c*RW +: RW]), m_b[c]);
      end
      for (int r = 0; r < NR; r++)
        chk("R8 R9", $sformatf("sb_ready[%0d][%0d]", c, r),
            int'(sb_ready[c*NR + r]), int'(m_sb[c][r]));
    end
    for (int c = 0; c < NC; c++) begin
      if (wb_valid[c]) m_sb[c][int'(wb_reg[c*RW +: RW])] = 1'b1;
      if (ei[c]) m_sb[c][m_d[c]] = 1'b0;
      if (flush) m_occ[c] = 1'b0;
      else if (ei[c]) m_occ[c] = 1'b0;
    end
    for (int k = 0; k < 2; k++) begin
      if (et[k]) begin
        int c;
        c = int'(q_cls[2*k +: 2]);
        m_occ[c] = 1'b1;
        m_d[c] = int'(q_dst[k*RW +: RW]);
        m_a[c] = int'(q_src_a[k*RW +: RW]);
        m_b[c] = int'(q_src_b[k*RW +: RW]);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < NC; c++) begin
      m_occ[c] = 1'b0; m_d[c] = 0; m_a[c] = 0; m_b[c] = 0;
      for (int r = 0; r < NR; r++) m_sb[c][r] = 1'b1;
    end
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    cycle("R1");
    // R6: integer and floating point together, both stations empty
    set_slot(0, 0, 1, 2, 3, 1'b1); set_slot(1, 1, 1, 2, 3, 1'b1);
    cycle("R6");
    idle_inputs();
    cycle("R7");           // both issue here
    cycle("R8");           // dst r1 now pending in classes 0 and 1
    // R4: same class pair, slot 0 taken but slot 1 held
    set_slot(0, 0, 4, 1, 0, 1'b1); set_slot(1, 0, 5, 0, 0, 1'b1);
    cycle("R4");
    // R3 R5: integer station busy (waits on r1), FP younger passes
    set_slot(0, 0, 5, 0, 0, 1'b1); set_slot(1, 1, 2, 0, 0, 1'b1);
    cycle("R3 R5");
    // R11: reserved class at head, special entry passes it
    set_slot(0, 3, 0, 0, 0, 1'b1); set_slot(1, 2, 0, 0, 0, 1'b1);
    cycle("R11");
    // R10: flush with integer station still occupied
    idle_inputs();
    flush = 1'b1; set_slot(0, 1, 3, 0, 0, 1'b1);
    cycle("R10");
    idle_inputs();
    set_slot(0, 0, 6, 0, 0, 1'b1);
    cycle("R10 R2");       // integer station free again after flush
    // R9: writeback class 0 r1 only; class 1 r1 stays pending
    idle_inputs();
    wb_valid = 3'b001; wb_reg = '0; wb_reg[0 +: RW] = RW'(1);
    cycle("R9");
    idle_inputs();
    cycle("R9");

    // seeded random traffic
    for (int n = 0; n < 4000; n++) begin
      idle_inputs();
      for (int k = 0; k < 2; k++) begin
        int cl;
        cl = ($urandom % 16 == 0) ? 3 : int'($urandom % 3);
        set_slot(k, cl, int'($urandom % NR), int'($urandom % NR),
                 int'($urandom % NR), bit'($urandom % 4 != 0));
      end
      for (int c = 0; c < NC; c++) begin
        wb_valid[c] = bit'($urandom % 2);
        wb_reg[c*RW +: RW] = RW'($urandom % NR);
      end
      flush = ($urandom % 64 == 0);
      cycle("R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule